// File: doc/BRIEF.md
# Transmit Descriptor Completion Sequencer

This block sits between a transmit DMA front end and the descriptor write-back path of a network controller. Each time the front end has consumed a descriptor, it hands over one in-order event with three command flags: report-status, report-packet-sent and end-of-packet. The block decides, for each descriptor in ring order, whether a done-status write-back must be requested and when the ring head pointer may move past it.

A report-status descriptor completes as soon as its data sits in the transmit FIFO. A report-packet-sent descriptor (valid only with end-of-packet) completes only when the MAC reports that the frame has left the wire or has been abandoned with an error. Until then the head pointer stays put and no later descriptor is written back. The front end may keep consuming descriptors while this wait lasts. Those events collect in a small in-order queue, and back-pressure is raised when the queue fills. A parameter removes report-packet-sent support, and the flag is then ignored.

Top module: `txc_wb_sequencer`

## Requirements
- R1: After reset, `head` is 0, `wb_valid` is 0 and `ev_ready` is 1.
- R2: A descriptor whose class is report-status (`ev_rs`=1 and not an active packet-sent request) yields exactly one `wb_valid` pulse with `wb_idx` equal to its ring index and `wb_err`=0, and `head` moves to the next index in the same cycle.
- R3: A descriptor with `ev_rs`=0 and no active packet-sent request advances `head` by one and produces no write-back.
- R4: A descriptor with `ev_rps`=1 and `ev_eop`=1 (with `RPS_EN`=1) produces no write-back and freezes `head` until `mac_sent` or `mac_err` is sampled high. The next cycle then carries its write-back with its index, `wb_err` equal to the sampled `mac_err`, and the head advance.
- R5: Events that arrive during a pending packet-sent wait are accepted and completed in arrival order after the wait ends, at most one descriptor per cycle.
- R6: `ev_rps`=1 with `ev_eop`=0 is treated as if `ev_rps` were 0.
- R7: With `RPS_EN`=0, `ev_rps` is ignored, and such a descriptor completes by its `ev_rs` flag alone.
- R8: `head` and ring indices count 0 to `RING`-1 and wrap to 0. `head` never changes by anything other than a single step.
- R9: `ev_ready` is 0 while the queue holds `DEPTH` events. An event offered while `ev_ready` is 0 is dropped.
- R10: `mac_sent` or `mac_err` arriving while no packet-sent wait is pending has no effect on `head` or on write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A descriptor-consumed event is offered |
| ev_ready | output | 1 | The event queue can take an event |
| ev_rs | input | 1 | Report-status flag of the event |
| ev_rps | input | 1 | Report-packet-sent flag of the event |
| ev_eop | input | 1 | End-of-packet flag of the event |
| mac_sent | input | 1 | Pulse: pending frame transmitted |
| mac_err | input | 1 | Pulse: pending frame ended in error |
| wb_valid | output | 1 | Write-back request, one cycle per descriptor |
| wb_idx | output | $clog2(RING) | Ring index to write back |
| wb_err | output | 1 | Write-back reports a transmit error |
| head | output | $clog2(RING) | Ring head pointer |

## Verification
The hardest state to reach is a full queue sitting behind a pending packet-sent descriptor. Reaching it needs the wait to begin, `DEPTH` more events to arrive before the MAC answers, and an extra event offered against low ready. A directed sequence holds back the MAC response, fills the queue and offers a surplus event. It then releases the wait with an error and checks that the completions resume in order. Constrained random traffic then mixes all flag combinations. A bench process answers each wait only after observing, at the ports, that the head has reached the waiting index, and it checks that nothing moves while it delays.

// File: rtl/txc_pkg.sv
package txc_pkg;

    // Completion class of a consumed descriptor
    typedef enum logic [1:0] {
        CK_SKIP = 2'd0,   // advance head only
        CK_RS   = 2'd1,   // write back once buffered
        CK_RPS  = 2'd2    // write back once the MAC reports
    } cmpl_kind_e;

endpackage

// File: rtl/txc_classify.sv
module txc_classify
    import txc_pkg::*;
#(
    parameter bit RPS_EN = 1'b1
) (
    input  logic       rs,
    input  logic       rps,
    input  logic       eop,
    output cmpl_kind_e kind
);

    // Packet-sent deferral needs the option and a packet end
    logic rps_active;
    assign rps_active = RPS_EN && rps && eop;

    always_comb begin
        if (rps_active)  kind = CK_RPS;
        else if (rs)     kind = CK_RS;
        else             kind = CK_SKIP;
    end

endmodule

// File: rtl/txc_ring_inc.sv
module txc_ring_inc #(
    parameter int RING = 16,
    localparam int IW  = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] nxt
);

    assign nxt = (idx == IW'(RING - 1)) ? '0 : idx + 1'b1;

endmodule

// File: rtl/txc_queue.sv
module txc_queue
    import txc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  cmpl_kind_e push_kind,
    input  logic       pop,
    output logic       empty,
    output logic       full,
    output cmpl_kind_e top_kind
);

    typedef struct packed {
        cmpl_kind_e [DEPTH-1:0] mem;
        logic [AW-1:0]          wr;
        logic [AW-1:0]          rd;
        logic [CW-1:0]          cnt;
    } q_t;

    q_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wr] = push_kind;
            q_d.wr = (q_q.wr == AW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (pop) begin
            q_d.rd = (q_q.rd == AW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign empty    = (q_q.cnt == '0);
    assign full     = (q_q.cnt == CW'(DEPTH));
    assign top_kind = q_q.mem[q_q.rd];

endmodule

// File: rtl/txc_wb_sequencer.sv
module txc_wb_sequencer
    import txc_pkg::*;
#(
    parameter int RING   = 16,
    parameter int DEPTH  = 4,
    parameter bit RPS_EN = 1'b1,
    localparam int IW    = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic          ev_rs,
    input  logic          ev_rps,
    input  logic          ev_eop,
    input  logic          mac_sent,
    input  logic          mac_err,
    output logic          wb_valid,
    output logic [IW-1:0] wb_idx,
    output logic          wb_err,
    output logic [IW-1:0] head
);

    typedef struct packed {
        logic [IW-1:0] head;
        logic          wb_valid;
        logic [IW-1:0] wb_idx;
        logic          wb_err;
        logic          pend;
    } seq_t;

    seq_t       state_q, state_d;
    cmpl_kind_e in_kind, top_kind;
    logic       q_empty, q_full, push, pop;
    logic [IW-1:0] head_nxt;

    txc_classify #(.RPS_EN(RPS_EN)) u_classify (
        .rs   (ev_rs),
        .rps  (ev_rps),
        .eop  (ev_eop),
        .kind (in_kind)
    );

    txc_ring_inc #(.RING(RING)) u_inc (
        .idx (state_q.head),
        .nxt (head_nxt)
    );

    assign push = ev_valid && !q_full;
    assign pop  = !q_empty && !state_q.pend;

    txc_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_kind (in_kind),
        .pop       (pop),
        .empty     (q_empty),
        .full      (q_full),
        .top_kind  (top_kind)
    );

    always_comb begin
        state_d          = state_q;
        state_d.wb_valid = 1'b0;
        state_d.wb_err   = 1'b0;
        if (state_q.pend) begin
            // Waiting on the wire: only the MAC outcome releases it
            if (mac_sent || mac_err) begin
                state_d.wb_valid = 1'b1;
                state_d.wb_idx   = state_q.head;
                state_d.wb_err   = mac_err;
                state_d.head     = head_nxt;
                state_d.pend     = 1'b0;
            end
        end else if (pop) begin
            case (top_kind)
                CK_RPS: state_d.pend = 1'b1;
                CK_RS: begin
                    state_d.wb_valid = 1'b1;
                    state_d.wb_idx   = state_q.head;
                    state_d.head     = head_nxt;
                end
                default: state_d.head = head_nxt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ev_ready = !q_full;
    assign wb_valid = state_q.wb_valid;
    assign wb_idx   = state_q.wb_idx;
    assign wb_err   = state_q.wb_err;
    assign head     = state_q.head;

endmodule

// File: rtl/txc_wb_checker.sv
module txc_wb_checker #(
    parameter int RING  = 16,
    localparam int IW   = (RING > 1) ? $clog2(RING) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mac_sent,
    input logic          mac_err,
    input logic          wb_valid,
    input logic [IW-1:0] wb_idx,
    input logic          wb_err,
    input logic [IW-1:0] head,
    input logic          pend
);

    function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
        return (v == IW'(RING - 1)) ? '0 : v + 1'b1;
    endfunction

    assert_wb_index_is_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> head == step(wb_idx));

    assert_head_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (head == $past(head)) || (head == step($past(head))));

    assert_hold_while_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !mac_sent && !mac_err) |=> (!wb_valid && $stable(head)));

    assert_err_needs_mac_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> (wb_valid && $past(mac_err)));

endmodule

bind txc_wb_sequencer txc_wb_checker #(.RING(RING)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mac_sent (mac_sent),
    .mac_err  (mac_err),
    .wb_valid (wb_valid),
    .wb_idx   (wb_idx),
    .wb_err   (wb_err),
    .head     (head),
    .pend     (state_q.pend)
);

// File: tb/test_txc_wb_sequencer.sv
module test_txc_wb_sequencer;

    localparam int RING  = 16;
    localparam int DEPTH = 4;
    localparam int IW    = $clog2(RING);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0, ev_rs = 1'b0, ev_rps = 1'b0, ev_eop = 1'b0;
    logic mac_sent = 1'b0, mac_err = 1'b0;
    logic ev_ready, wb_valid, wb_err;
    logic [IW-1:0] wb_idx, head;
    logic n_ready, n_wb_valid, n_wb_err, n_ev_valid;
    logic [IW-1:0] n_wb_idx, n_head;

    always #5 clk = ~clk;

    txc_wb_sequencer #(.RING(RING), .DEPTH(DEPTH), .RPS_EN(1'b1)) i_txc_wb_sequencer (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_rs(ev_rs), .ev_rps(ev_rps), .ev_eop(ev_eop),
        .mac_sent(mac_sent), .mac_err(mac_err),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_err(wb_err), .head(head)
    );

    // Same event stream, packet-sent option removed
    assign n_ev_valid = ev_valid && ev_ready;
    txc_wb_sequencer #(.RING(RING), .DEPTH(DEPTH), .RPS_EN(1'b0)) i_txc_wb_sequencer_norps (
        .clk(clk), .rst_n(rst_n), .ev_valid(n_ev_valid), .ev_ready(n_ready),
        .ev_rs(ev_rs), .ev_rps(ev_rps), .ev_eop(ev_eop),
        .mac_sent(mac_sent), .mac_err(mac_err),
        .wb_valid(n_wb_valid), .wb_idx(n_wb_idx), .wb_err(n_wb_err), .head(n_head)
    );

    int n_cmp = 0, n_bad = 0;
    int total = 0;
    int exp_idx[$];
    bit exp_err[$];
    int rps_idx[$];
    bit rps_err[$];
    int norps_exp = 0, norps_seen = 0;
    bit mac_auto = 1'b0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected completion class, from R4/R6/R2/R3
    function automatic int kind_of(input bit rs, input bit rps, input bit eop);
        if (rps && eop) return 2;
        if (rs)         return 1;
        return 0;
    endfunction

    // Scoreboard for write-backs (R2, R4, R5)
    always @(negedge clk) begin
        if (rst_n && wb_valid) begin
            if (exp_idx.size() == 0) begin
                check("R2 unexpected write-back", 1, 0);
            end else begin
                check("R5 write-back index in order", int'(wb_idx), exp_idx[0]);
                check("R4 write-back error flag", int'(wb_err), int'(exp_err[0]));
                void'(exp_idx.pop_front());
                void'(exp_err.pop_front());
            end
        end
        if (rst_n && n_wb_valid) norps_seen++;
    end

    task automatic send(input bit rs, input bit rps, input bit eop, input bit err);
        int k;
        while (!ev_ready) @(negedge clk);
        ev_valid = 1'b1; ev_rs = rs; ev_rps = rps; ev_eop = eop;
        k = kind_of(rs, rps, eop);
        if (k == 2) begin
            exp_idx.push_back(total % RING); exp_err.push_back(err);
            rps_idx.push_back(total % RING); rps_err.push_back(err);
        end else if (k == 1) begin
            exp_idx.push_back(total % RING); exp_err.push_back(1'b0);
        end
        if (rs) norps_exp++;
        total++;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic release_one(input bit err);
        mac_sent = !err; mac_err = err;
        @(negedge clk);
        mac_sent = 1'b0; mac_err = 1'b0;
    endtask

    // MAC responder: answers a deferred descriptor once head reaches it
    initial begin
        forever begin
            @(negedge clk);
            if (mac_auto && rps_idx.size() > 0 && int'(head) == rps_idx[0]) begin
                int wait_n;
                wait_n = 2 + int'($urandom % 4);
                for (int i = 0; i < wait_n; i++) begin
                    @(negedge clk);
                    check("R4 head frozen while pending", int'(head), rps_idx[0]);
                    check("R4 no write-back while pending", int'(wb_valid), 0);
                end
                mac_sent = !rps_err[0]; mac_err = rps_err[0];
                void'(rps_idx.pop_front());
                void'(rps_err.pop_front());
                @(negedge clk);
                mac_sent = 1'b0; mac_err = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 head after reset", int'(head), 0);
        check("R1 wb_valid after reset", int'(wb_valid), 0);
        check("R1 ev_ready after reset", int'(ev_ready), 1);

        // R10 MAC outcome with nothing pending
        release_one(1'b0);
        release_one(1'b1);
        repeat (2) @(negedge clk);
        check("R10 head unchanged by idle MAC pulse", int'(head), 0);
        check("R10 no write-back from idle MAC pulse", int'(wb_valid), 0);

        // R3 plain descriptor
        send(1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R3 head advanced", int'(head), 1);
        check("R3 no write-back", int'(wb_valid), 0);

        // R2 report-status descriptor
        send(1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check("R2 wb_valid", int'(wb_valid), 1);
        check("R2 wb_idx", int'(wb_idx), 1);
        check("R2 head", int'(head), 2);

        // R6 packet-sent without end-of-packet acts as report-status
        send(1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check("R6 wb_valid", int'(wb_valid), 1);
        check("R6 wb_idx", int'(wb_idx), 2);
        check("R6 head", int'(head), 3);

        // R4/R7/R9/R5: hold a packet-sent wait, fill the queue, release with error
        send(1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R4 no immediate write-back", int'(wb_valid), 0);
        check("R7 disabled option writes back at once", int'(n_wb_valid), 1);
        check("R7 disabled option index", int'(n_wb_idx), 3);
        void'(rps_idx.pop_front());
        void'(rps_err.pop_front());
        for (int i = 0; i < DEPTH; i++) send(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 ready low when queue full", int'(ev_ready), 0);
        check("R4 head frozen", int'(head), 3);
        ev_valid = 1'b1; ev_rs = 1'b1; ev_rps = 1'b0; ev_eop = 1'b1;
        repeat (2) @(negedge clk);
        ev_valid = 1'b0;
        release_one(1'b1);
        repeat (DEPTH + 3) @(negedge clk);
        check("R5 R9 head after release and drop", int'(head), (4 + DEPTH) % RING);
        check("R9 ready back high", int'(ev_ready), 1);
        check("R5 all queued write-backs seen", exp_idx.size(), 0);

        // Random traffic
        mac_auto = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            bit rs, rps, eop, er;
            rs  = ($urandom % 2) == 0;
            rps = ($urandom % 6) == 0;
            eop = ($urandom % 4) != 0;
            er  = ($urandom % 3) == 0;
            send(rs, rps, eop, er);
            if (($urandom % 5) == 0) @(negedge clk);
        end
        while (exp_idx.size() != 0 || rps_idx.size() != 0) @(negedge clk);
        repeat (DEPTH + 4) @(negedge clk);
        check("R8 head wraps to event count modulo ring", int'(head), total % RING);
        check("R7 disabled-option head", int'(n_head), total % RING);
        check("R7 disabled-option write-back count", norps_seen, norps_exp);
        check("R3 no write-back left over", exp_idx.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule